// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Flags

This block keeps one interrupt flag for each side of a two-port memory. The two sides are called left and right. Each side has its own chip select, write strobe, output enable and address bus, and the block samples all of them on a shared clock. A side gets an interrupt when the other side writes to that side's mailbox word. The interrupt stays up until the owning side reads the same word back. The memory array itself lies outside this block. The block only watches the accesses and keeps the two flags.

Both mailbox words sit at the top of the address space, so they move when the address width changes. The left mailbox is the all-ones address minus one, and the right mailbox is the all-ones address. A global enable input decides whether mailbox writes may raise flags at all, which lets a system that does not use the mailbox leave it switched off. Each flag drives an active-low interrupt output through a register.

Top module: `mbox_irq`

## Requirements
- R1: While reset is asserted, and after it is released with no access, both `lt_irq_n` and `rt_irq_n` are high (inactive).
- R2: A side writes on a rising clock edge when its `cs_n` and `we_n` are both low. While `cs_n` is high, that side makes no access, whatever its other pins are.
- R3: If `mbox_en` is high and the right side writes to address 2^AW-2, `lt_irq_n` is low from the next clock edge on.
- R4: If `mbox_en` is high and the left side writes to address 2^AW-1, `rt_irq_n` is low from the next clock edge on.
- R5: A left-side read of address 2^AW-2 sets `lt_irq_n` high at the next edge. A read means `cs_n` low, `oe_n` low and `we_n` high. If `oe_n` is high, the access does not clear the flag.
- R6: A right-side read of address 2^AW-1, under the same read definition as R5, sets `rt_irq_n` high at the next edge.
- R7: If a flag's set condition and clear condition occur on the same edge, the flag ends up set (output low).
- R8: While `mbox_en` is low, no flag can be set. Clearing by a read still works.
- R9: A flag keeps its value on any edge with neither a set nor a clear of that flag. This includes a side writing its own mailbox and any access to another address.
- R10: Only the AW address bits are compared, so both mailbox addresses follow the AW parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mbox_en | input | 1 | Lets mailbox writes raise flags |
| lt_cs_n | input | 1 | Left chip select, active low |
| lt_we_n | input | 1 | Left write strobe, low = write |
| lt_oe_n | input | 1 | Left output enable, active low |
| lt_addr | input | AW | Left address |
| rt_cs_n | input | 1 | Right chip select, active low |
| rt_we_n | input | 1 | Right write strobe, low = write |
| rt_oe_n | input | 1 | Right output enable, active low |
| rt_addr | input | AW | Right address |
| lt_irq_n | output | 1 | Left interrupt, active low |
| rt_irq_n | output | 1 | Right interrupt, active low |

## Verification
The bench builds two copies of the block side by side, one with AW=5 and one with the default AW=17, and drives both from the same 17-bit stimulus. The narrow copy sees only the low five address bits. In that copy, random addresses land on the mailbox words often, so same-edge set-and-clear collisions and repeated set/clear cycles occur in the random phase. In the wide copy, the same addresses almost never match unless they are aimed at 0x1FFFE or 0x1FFFF. Comparing the two copies therefore shows that the mailbox positions follow the width.

// File: rtl/mbox_irq.sv
module mbox_irq #(
  parameter int AW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mbox_en,
  input  logic          lt_cs_n,
  input  logic          lt_we_n,
  input  logic          lt_oe_n,
  input  logic [AW-1:0] lt_addr,
  input  logic          rt_cs_n,
  input  logic          rt_we_n,
  input  logic          rt_oe_n,
  input  logic [AW-1:0] rt_addr,
  output logic          lt_irq_n,
  output logic          rt_irq_n
);
  localparam logic [AW-1:0] MBOX_RT = '1;
  localparam logic [AW-1:0] MBOX_LT = MBOX_RT - AW'(1);

  logic lt_wr, lt_rd, rt_wr, rt_rd;
  logic set_lt, clr_lt, set_rt, clr_rt;
  logic flag_lt, flag_rt;

  assign lt_wr = !lt_cs_n && !lt_we_n;
  assign lt_rd = !lt_cs_n && !lt_oe_n && lt_we_n;
  assign rt_wr = !rt_cs_n && !rt_we_n;
  assign rt_rd = !rt_cs_n && !rt_oe_n && rt_we_n;

  assign set_lt = mbox_en && rt_wr && (rt_addr == MBOX_LT);
  assign clr_lt = lt_rd && (lt_addr == MBOX_LT);
  assign set_rt = mbox_en && lt_wr && (lt_addr == MBOX_RT);
  assign clr_rt = rt_rd && (rt_addr == MBOX_RT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_lt <= 1'b0;
      flag_rt <= 1'b0;
    end else begin
      if (set_lt)      flag_lt <= 1'b1;
      else if (clr_lt) flag_lt <= 1'b0;
      if (set_rt)      flag_rt <= 1'b1;
      else if (clr_rt) flag_rt <= 1'b0;
    end
  end

  assign lt_irq_n = ~flag_lt;
  assign rt_irq_n = ~flag_rt;

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> (lt_irq_n && rt_irq_n));

  assert_lt_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mbox_en && !rt_cs_n && !rt_we_n && rt_addr == MBOX_LT) |=> !lt_irq_n);

  assert_rt_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mbox_en && !lt_cs_n && !lt_we_n && lt_addr == MBOX_RT) |=> !rt_irq_n);

  assert_lt_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!lt_cs_n && !lt_oe_n && lt_we_n && lt_addr == MBOX_LT && !set_lt) |=> lt_irq_n);

  assert_rt_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rt_cs_n && !rt_oe_n && rt_we_n && rt_addr == MBOX_RT && !set_rt) |=> rt_irq_n);

  assert_gate_lt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lt_irq_n) |-> $past(mbox_en));

  assert_gate_rt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rt_irq_n) |-> $past(mbox_en));

  assert_hold_lt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_cs_n && lt_cs_n) |=> $stable(lt_irq_n));

  assert_hold_rt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_cs_n && lt_cs_n) |=> $stable(rt_irq_n));
endmodule

// File: tb/mbox_irq_bench.sv
module mbox_irq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NAW = 5;
  localparam int WAW = 17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mbox_en = 1'b0;
  logic lt_cs_n = 1'b1, lt_we_n = 1'b1, lt_oe_n = 1'b1;
  logic rt_cs_n = 1'b1, rt_we_n = 1'b1, rt_oe_n = 1'b1;
  logic [16:0] lt_addr = '0, rt_addr = '0;
  logic n_lt_irq_n, n_rt_irq_n, w_lt_irq_n, w_rt_irq_n;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic e_nlt = 1'b0, e_nrt = 1'b0, e_wlt = 1'b0, e_wrt = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbox_irq #(.AW(NAW)) u_mbox_irq (
    .clk(clk), .rst_n(rst_n), .mbox_en(mbox_en),
    .lt_cs_n(lt_cs_n), .lt_we_n(lt_we_n), .lt_oe_n(lt_oe_n), .lt_addr(lt_addr[NAW-1:0]),
    .rt_cs_n(rt_cs_n), .rt_we_n(rt_we_n), .rt_oe_n(rt_oe_n), .rt_addr(rt_addr[NAW-1:0]),
    .lt_irq_n(n_lt_irq_n), .rt_irq_n(n_rt_irq_n));

  mbox_irq #(.AW(WAW)) u_mbox_irq_wide (
    .clk(clk), .rst_n(rst_n), .mbox_en(mbox_en),
    .lt_cs_n(lt_cs_n), .lt_we_n(lt_we_n), .lt_oe_n(lt_oe_n), .lt_addr(lt_addr),
    .rt_cs_n(rt_cs_n), .rt_we_n(rt_we_n), .rt_oe_n(rt_oe_n), .rt_addr(rt_addr),
    .lt_irq_n(w_lt_irq_n), .rt_irq_n(w_rt_irq_n));

  function automatic logic hits(logic [16:0] a, int aw, int off);
    logic [16:0] m;
    m = 17'h1FFFF >> (17 - aw);
    return (a & m) == 17'(m - 17'(off));
  endfunction

  function automatic logic next_flag(logic cur, logic set, logic clr);
    return set ? 1'b1 : (clr ? 1'b0 : cur);
  endfunction

  task automatic check(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag);
    logic lwr, lrd, rwr, rrd;
    lwr = !lt_cs_n && !lt_we_n;
    lrd = !lt_cs_n && !lt_oe_n && lt_we_n;
    rwr = !rt_cs_n && !rt_we_n;
    rrd = !rt_cs_n && !rt_oe_n && rt_we_n;
    e_nlt = next_flag(e_nlt, mbox_en && rwr && hits(rt_addr, NAW, 1), lrd && hits(lt_addr, NAW, 1));
    e_nrt = next_flag(e_nrt, mbox_en && lwr && hits(lt_addr, NAW, 0), rrd && hits(rt_addr, NAW, 0));
    e_wlt = next_flag(e_wlt, mbox_en && rwr && hits(rt_addr, WAW, 1), lrd && hits(lt_addr, WAW, 1));
    e_wrt = next_flag(e_wrt, mbox_en && lwr && hits(lt_addr, WAW, 0), rrd && hits(rt_addr, WAW, 0));
    @(posedge clk);
    @(negedge clk);
    check(tag, "narrow lt_irq_n", n_lt_irq_n, ~e_nlt);
    check(tag, "narrow rt_irq_n", n_rt_irq_n, ~e_nrt);
    check(tag, "wide lt_irq_n", w_lt_irq_n, ~e_wlt);
    check(tag, "wide rt_irq_n", w_rt_irq_n, ~e_wrt);
  endtask

  task automatic idle();
    lt_cs_n = 1'b1; lt_we_n = 1'b1; lt_oe_n = 1'b1;
    rt_cs_n = 1'b1; rt_we_n = 1'b1; rt_oe_n = 1'b1;
  endtask

  task automatic lt_acc(logic wr, logic oe, logic [16:0] a);
    lt_cs_n = 1'b0; lt_we_n = !wr; lt_oe_n = !oe; lt_addr = a;
  endtask

  task automatic rt_acc(logic wr, logic oe, logic [16:0] a);
    rt_cs_n = 1'b0; rt_we_n = !wr; rt_oe_n = !oe; rt_addr = a;
  endtask

  function automatic logic [16:0] pick_addr();
    case ($urandom_range(0, 3))
      0: return 17'h1FFFE;
      1: return 17'h1FFFF;
      default: return 17'($urandom);
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    check("R1", "narrow lt_irq_n in reset", n_lt_irq_n, 1'b1);
    check("R1", "wide rt_irq_n in reset", w_rt_irq_n, 1'b1);
    rst_n = 1'b1;
    mbox_en = 1'b1;
    idle();
    step("R1");

    rt_acc(1, 0, 17'h1FFFE); step("R3");
    idle(); step("R9");
    lt_acc(0, 0, 17'h1FFFE); step("R5");
    lt_acc(0, 1, 17'h1FFFE); step("R5");
    lt_acc(1, 0, 17'h1FFFF); step("R4");
    idle(); rt_acc(1, 0, 17'h1FFFF); step("R9");
    rt_acc(0, 1, 17'h0123F); step("R9");
    rt_acc(0, 1, 17'h1FFFF); step("R6");
    idle(); rt_cs_n = 1'b1; rt_we_n = 1'b0; rt_addr = 17'h1FFFE; step("R2");
    idle(); mbox_en = 1'b0; rt_acc(1, 0, 17'h1FFFE); step("R8");
    mbox_en = 1'b1; step("R8");
    idle(); mbox_en = 1'b0; lt_acc(0, 1, 17'h1FFFE); step("R8");
    idle(); mbox_en = 1'b1; rt_acc(1, 0, 17'h1FFFE); lt_acc(0, 1, 17'h1FFFE); step("R7");
    idle(); lt_acc(1, 0, 17'h1FFFF); rt_acc(0, 1, 17'h1FFFF); step("R7");
    idle(); rt_acc(1, 0, 17'h0001E); step("R10");
    idle(); lt_acc(1, 0, 17'h0001F); step("R10");
    idle(); lt_acc(0, 1, 17'h1FFFE); rt_acc(0, 1, 17'h1FFFF); step("R10");

    for (int i = 0; i < 4000; i++) begin
      mbox_en = ($urandom_range(0, 7) != 0);
      lt_cs_n = ($urandom_range(0, 3) == 0);
      lt_we_n = $urandom_range(0, 1);
      lt_oe_n = ($urandom_range(0, 3) == 0);
      lt_addr = pick_addr();
      rt_cs_n = ($urandom_range(0, 3) == 0);
      rt_we_n = $urandom_range(0, 1);
      rt_oe_n = ($urandom_range(0, 3) == 0);
      rt_addr = pick_addr();
      step("R3 R4 R5 R6 random");
    end

    idle();
    rst_n = 1'b0;
    e_nlt = 1'b0; e_nrt = 1'b0; e_wlt = 1'b0; e_wrt = 1'b0;
    @(negedge clk);
    check("R1", "narrow lt_irq_n after late reset", n_lt_irq_n, 1'b1);
    check("R1", "wide lt_irq_n after late reset", w_lt_irq_n, 1'b1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule